// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes one incoming packet at a time from a byte stream and places it into host memory through a ring of receive descriptors. Each descriptor is 8 bytes long. It names a buffer, carries a status byte that says who owns it, and has a field where the received length is reported. When a packet starts, the engine scans the ring from its current position for an entry that the host has handed over. It reads that entry's buffer address and copies the packet bytes into the buffer. It then writes back the length, plus four bytes for the frame check sequence, and returns the entry to the host. Last, it raises a one-cycle receive event.

If no entry is available, the packet is consumed and thrown away and a missed-packet event fires. While the controller is stopped, packets are consumed and ignored without touching memory. The memory side is a byte-wide request port with a fixed one-cycle read latency. The stream side is a valid/ready byte interface with an end-of-packet marker.

State machine. The states are IDLE, LOOK, CHECK, FETCH, DATA, LEN_HI, LEN_LO, CLOSE, MISS and DISCARD.
- IDLE → DISCARD when a byte is offered and stop is high.
- IDLE → LOOK when a byte is offered and stop is low. This loads the search cursor from the ring pointer.
- LOOK → CHECK. LOOK issues the status read.
- CHECK → FETCH when the status byte is owned.
- CHECK → LOOK on a non-owned entry with search budget left. The cursor steps on.
- CHECK → MISS when the budget is used up.
- FETCH → DATA after three address-byte reads and their captures.
- DATA → LEN_HI on the accepted last byte.
- LEN_HI → LEN_LO → CLOSE → IDLE.
- MISS → DISCARD.
- DISCARD → IDLE on the accepted last byte.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, in_ready_o, mem_req_o, rint_o, intr_o, irq_o and miss_o are low, and the ring pointer is at entry 0, so the first packet is written to entry 0.
- R2: Descriptor i starts at ring_base_i + 8*i. Multi-byte fields are stored with the more significant byte at the lower address. Byte offsets 0 and 1 hold buffer address bits 15:8 and 7:0. Offset 2 is the status byte. Offset 3 holds buffer address bits 23:16. Offsets 6 and 7 hold the message length, high byte first.
- R3: An entry is taken only if its status byte is exactly 0x80. Any other value, including 0x81, is skipped.
- R4: The scan starts at the ring pointer and moves up modulo the ring size. It examines at most ring-size minus one entries, so the entry just before the pointer is never examined.
- R5: Packet byte k is written to buffer address + k, in arrival order.
- R6: After the last data byte, the engine writes the message length (packet bytes + 4) to offsets 6 and 7, then writes 0x03 to the status byte. The status write is the last memory write for the packet.
- R7: When an entry is filled, the ring pointer moves to that entry's index + 1, modulo the ring size.
- R8: rint_o and intr_o pulse for exactly one cycle, in the same cycle as the status write. irq_o pulses in that cycle only if inea_i is high.
- R9: If stop_i is high when a packet's first byte is offered, the whole packet is accepted and discarded. No memory access and no event occur, and the pointer does not change.
- R10: If the scan finds no usable entry, miss_o pulses once. The packet is accepted and discarded with no memory write, and the pointer does not change.
- R11: in_ready_o is high only in the data and discard phases. It is low when the first byte is offered, during the scan and address fetch, and during write-back. No memory read is issued while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Controller stopped; packets are ignored |
| inea_i | input | 1 | Interrupt enable for irq_o |
| ring_base_i | input | ADDR_W | Byte address of descriptor 0 |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_last_i | input | 1 | Marks the final byte of a packet |
| in_ready_o | output | 1 | Stream byte accepted when high with valid |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after the read request |
| rint_o | output | 1 | Receive-done event pulse |
| intr_o | output | 1 | Summary interrupt event pulse |
| irq_o | output | 1 | Interrupt pulse, gated by inea_i |
| miss_o | output | 1 | Missed-packet event pulse |

## Verification
The hardest case to reach from the ports is a scan that runs out while the only owned entry is the one just behind the pointer. That entry must be skipped and the packet reported as missed. To get there, the bench first fills entries so that the pointer wraps back to zero. It then marks every entry except the last as not owned, including one with the near-miss status 0x81, and leaves the last entry owned before offering a packet. A reference model in the bench scans its own copy of memory. It predicts the exact sequence of memory writes and the events, and every write on every clock is compared against that prediction.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOOK,
        ST_CHECK,
        ST_FETCH,
        ST_DATA,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_CLOSE,
        ST_MISS,
        ST_DISCARD
    } rxr_state_e;

    // status byte encodings
    localparam logic [7:0] DSC_OWNED = 8'h80;
    localparam logic [7:0] DSC_DONE  = 8'h03;

    // byte offsets inside one descriptor (big-endian fields)
    localparam int OFF_BUF_MID  = 0;
    localparam int OFF_BUF_LOW  = 1;
    localparam int OFF_STATUS   = 2;
    localparam int OFF_BUF_TOP  = 3;
    localparam int OFF_MLEN_HI  = 6;
    localparam int OFF_MLEN_LO  = 7;

    localparam int DESC_SHIFT   = 3;   // 8-byte entries
    localparam int MLEN_W       = 16;
    localparam int FCS_BYTES    = 4;
    localparam int BUFA_W       = 24;

endpackage

// File: rtl/rxr_cursor.sv
module rxr_cursor #(
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            step_i,
    input  logic            commit_i,
    output logic [IDXW-1:0] cur_o,
    output logic            last_try_o
);
    localparam logic [IDXW-1:0] LAST_TRY = {IDXW{1'b1}} - IDXW'(1);

    logic [IDXW-1:0] ptr_q;
    logic [IDXW-1:0] cur_q;
    logic [IDXW-1:0] tries_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            cur_q   <= '0;
            tries_q <= '0;
        end else begin
            if (start_i) begin
                cur_q   <= ptr_q;
                tries_q <= '0;
            end else if (step_i) begin
                cur_q   <= cur_q + IDXW'(1);
                tries_q <= tries_q + IDXW'(1);
            end
            if (commit_i) begin
                ptr_q <= cur_q + IDXW'(1);
            end
        end
    end

    assign cur_o      = cur_q;
    assign last_try_o = (tries_q == LAST_TRY);

    // R4: the controller never steps past the search budget
    a_r4_search_budget: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !last_try_o);

    // R7: the ring pointer moves only after a fill is committed
    a_r7_ptr_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_q) |-> $past(commit_i));

endmodule

// File: rtl/rxr_bytecount.sv
module rxr_bytecount
    import rxr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [MLEN_W-1:0] mlen_o
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count_o = count_q;
    assign mlen_o  = MLEN_W'(count_q) + MLEN_W'(FCS_BYTES);

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int AW    = 24,
    parameter int IDXW  = 2,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_i,
    input  logic              inea_i,
    input  logic [AW-1:0]     ring_base_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    input  logic              in_last_i,
    output logic              in_ready_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    input  logic [IDXW-1:0]   cur_i,
    input  logic              last_try_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [MLEN_W-1:0] mlen_i,
    output logic              start_o,
    output logic              step_o,
    output logic              commit_o,
    output logic              cnt_clr_o,
    output logic              cnt_inc_o,
    output logic              rint_o,
    output logic              intr_o,
    output logic              irq_o,
    output logic              miss_o
);
    rxr_state_e        state_q, state_d;
    logic [1:0]        fk_q;
    logic [BUFA_W-1:0] bufa_q;
    logic [AW-1:0]     desc_base;
    logic              owned;

    assign desc_base = ring_base_i + (AW'(cur_i) << DESC_SHIFT);
    assign owned     = (mem_rdata_i == DSC_OWNED);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (in_valid_i) state_d = stop_i ? ST_DISCARD : ST_LOOK;
            ST_LOOK:    state_d = ST_CHECK;
            ST_CHECK: begin
                if (owned)           state_d = ST_FETCH;
                else if (last_try_i) state_d = ST_MISS;
                else                 state_d = ST_LOOK;
            end
            ST_FETCH:   if (fk_q == 2'd3) state_d = ST_DATA;
            ST_DATA:    if (in_valid_i && in_last_i) state_d = ST_LEN_HI;
            ST_LEN_HI:  state_d = ST_LEN_LO;
            ST_LEN_LO:  state_d = ST_CLOSE;
            ST_CLOSE:   state_d = ST_IDLE;
            ST_MISS:    state_d = ST_DISCARD;
            ST_DISCARD: if (in_valid_i && in_last_i) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register plus fetch sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fk_q    <= '0;
            bufa_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FETCH) begin
                fk_q <= fk_q + 2'd1;
                unique case (fk_q)
                    2'd1:    bufa_q[15:8]  <= mem_rdata_i;
                    2'd2:    bufa_q[7:0]   <= mem_rdata_i;
                    2'd3:    bufa_q[23:16] <= mem_rdata_i;
                    default: ;
                endcase
            end else begin
                fk_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready_o  = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = desc_base;
        mem_wdata_o = 8'h00;
        start_o     = 1'b0;
        step_o      = 1'b0;
        commit_o    = 1'b0;
        cnt_clr_o   = 1'b0;
        cnt_inc_o   = 1'b0;
        rint_o      = 1'b0;
        intr_o      = 1'b0;
        irq_o       = 1'b0;
        miss_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start_o   = in_valid_i && !stop_i;
                cnt_clr_o = in_valid_i && !stop_i;
            end
            ST_LOOK: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_base + AW'(OFF_STATUS);
            end
            ST_CHECK: begin
                step_o = !owned && !last_try_i;
            end
            ST_FETCH: begin
                if (fk_q != 2'd3) begin
                    mem_req_o = 1'b1;
                    unique case (fk_q)
                        2'd0:    mem_addr_o = desc_base + AW'(OFF_BUF_MID);
                        2'd1:    mem_addr_o = desc_base + AW'(OFF_BUF_LOW);
                        default: mem_addr_o = desc_base + AW'(OFF_BUF_TOP);
                    endcase
                end
            end
            ST_DATA: begin
                in_ready_o = 1'b1;
                if (in_valid_i) begin
                    mem_req_o   = 1'b1;
                    mem_we_o    = 1'b1;
                    mem_addr_o  = AW'(bufa_q) + AW'(count_i);
                    mem_wdata_o = in_data_i;
                    cnt_inc_o   = 1'b1;
                end
            end
            ST_LEN_HI: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_base + AW'(OFF_MLEN_HI);
                mem_wdata_o = mlen_i[15:8];
            end
            ST_LEN_LO: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_base + AW'(OFF_MLEN_LO);
                mem_wdata_o = mlen_i[7:0];
            end
            ST_CLOSE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_base + AW'(OFF_STATUS);
                mem_wdata_o = DSC_DONE;
                commit_o    = 1'b1;
                rint_o      = 1'b1;
                intr_o      = 1'b1;
                irq_o       = inea_i;
            end
            ST_MISS: begin
                miss_o = 1'b1;
            end
            ST_DISCARD: begin
                in_ready_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R11: descriptor reads only happen while the stream is held off
    a_r11_no_read_while_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |-> !in_ready_o);

    // R8: one receive event per filled descriptor
    a_r8_single_rint: assert property (@(posedge clk) disable iff (!rst_n)
        rint_o |=> !rint_o);

    // R9: a packet offered while stopped causes no memory access
    a_r9_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && in_valid_i && stop_i) |=> !mem_req_o);

    // R10: a missed packet leads to no memory write
    a_r10_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |=> !mem_we_o);

endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
    import rxr_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int RING_LOG2 = 2,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_i,
    input  logic              inea_i,
    input  logic [ADDR_W-1:0] ring_base_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    input  logic              in_last_i,
    output logic              in_ready_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              rint_o,
    output logic              intr_o,
    output logic              irq_o,
    output logic              miss_o
);
    logic [RING_LOG2-1:0] cur;
    logic                 last_try;
    logic [CNT_W-1:0]     count;
    logic [MLEN_W-1:0]    mlen;
    logic                 start, step, commit, cnt_clr, cnt_inc;

    rxr_cursor #(.IDXW(RING_LOG2)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .step_i     (step),
        .commit_i   (commit),
        .cur_o      (cur),
        .last_try_o (last_try)
    );

    rxr_bytecount #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .count_o (count),
        .mlen_o  (mlen)
    );

    rxr_ctrl #(.AW(ADDR_W), .IDXW(RING_LOG2), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_i      (stop_i),
        .inea_i      (inea_i),
        .ring_base_i (ring_base_i),
        .in_valid_i  (in_valid_i),
        .in_data_i   (in_data_i),
        .in_last_i   (in_last_i),
        .in_ready_o  (in_ready_o),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .cur_i       (cur),
        .last_try_i  (last_try),
        .count_i     (count),
        .mlen_i      (mlen),
        .start_o     (start),
        .step_o      (step),
        .commit_o    (commit),
        .cnt_clr_o   (cnt_clr),
        .cnt_inc_o   (cnt_inc),
        .rint_o      (rint_o),
        .intr_o      (intr_o),
        .irq_o       (irq_o),
        .miss_o      (miss_o)
    );

endmodule

// File: tb/sim_rx_ring_engine.sv
module sim_rx_ring_engine;
    localparam int AW   = 24;
    localparam int RL   = 2;
    localparam int N    = 4;
    localparam int BASE = 'h001000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_i = 1'b0, inea_i = 1'b1;
    logic [AW-1:0] ring_base = AW'(BASE);
    logic          in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_ready, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          rint, intr, irq, miss;

    always #5 clk = ~clk;

    rx_ring_engine #(.ADDR_W(AW), .RING_LOG2(RL)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .inea_i(inea_i),
        .ring_base_i(ring_base), .in_valid_i(in_valid), .in_data_i(in_data),
        .in_last_i(in_last), .in_ready_o(in_ready), .mem_req_o(mem_req),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .rint_o(rint), .intr_o(intr), .irq_o(irq),
        .miss_o(miss)
    );

    // behavioural host memory, one-cycle read latency
    logic [7:0] mem [int];
    function automatic logic [7:0] rd(int a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= rd(int'(mem_addr));
        if (mem_req && mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    int checks = 0, fails = 0, cyc = 0;
    int q_a[$];
    logic [7:0] q_d[$];
    string q_t[$];
    int n_rint = 0, n_intr = 0, n_irq = 0, n_miss = 0;
    int mptr = 0;
    int ea;
    logic [7:0] ed;
    string et;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model's write stream
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_we) begin
                if (q_a.size() == 0) begin
                    chk(1'b0, "R5 unexpected write", int'({mem_addr, mem_wdata}), 0);
                end else begin
                    ea = q_a.pop_front();
                    ed = q_d.pop_front();
                    et = q_t.pop_front();
                    chk(int'(mem_addr) == ea && mem_wdata == ed, et,
                        int'({mem_addr, mem_wdata}), int'({ea[23:0], ed}));
                end
            end
            if (rint) begin
                n_rint++;
                chk(mem_we && mem_wdata == 8'h03, "R8 rint with status write",
                    int'({mem_we, mem_wdata}), 'h103);
            end
            if (intr) n_intr++;
            if (irq)  n_irq++;
            if (miss) n_miss++;
            if (in_ready && mem_req && !mem_we)
                chk(1'b0, "R11 read while ready", 1, 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog actual=%0d expected=finished", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [7:0] pbyte(int seed, int k);
        return 8'(seed + k * 7);
    endfunction

    task automatic set_desc(int idx, int bufa, logic [7:0] st);
        int d = BASE + idx * 8;
        mem[d + 0] = 8'(bufa >> 8);
        mem[d + 1] = 8'(bufa);
        mem[d + 2] = st;
        mem[d + 3] = 8'(bufa >> 16);
    endtask

    // reference model: R2 layout, R3 exact match, R4 bounded scan
    task automatic predict(int len, int seed, output bit filled, output bit missed);
        int idx = mptr;
        int d, bufa, ml;
        filled = 1'b0;
        missed = 1'b0;
        if (stop_i) return;                 // R9
        for (int t = 0; t < N - 1; t++) begin
            if (rd(BASE + idx * 8 + 2) == 8'h80) begin
                filled = 1'b1;
                break;
            end
            idx = (idx + 1) % N;
        end
        if (!filled) begin
            missed = 1'b1;                  // R10
            return;
        end
        d = BASE + idx * 8;
        bufa = (int'(rd(d + 3)) << 16) | (int'(rd(d)) << 8) | int'(rd(d + 1));
        for (int k = 0; k < len; k++) begin
            q_a.push_back(bufa + k); q_d.push_back(pbyte(seed, k)); q_t.push_back("R5 data");
        end
        ml = len + 4;
        q_a.push_back(d + 6); q_d.push_back(8'(ml >> 8)); q_t.push_back("R6 length high");
        q_a.push_back(d + 7); q_d.push_back(8'(ml));      q_t.push_back("R6 length low");
        q_a.push_back(d + 2); q_d.push_back(8'h03);       q_t.push_back("R6 status done");
        mptr = (idx + 1) % N;               // R7
    endtask

    task automatic send(int len, int seed, int gap);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pbyte(seed, k);
            in_last  = (k == len - 1);
            #1;
            if (k == 0) chk(in_ready == 1'b0, "R11 ready low at first byte", in_ready, 0);
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            in_last  = 1'b0;
            if (gap > 0) repeat (gap) @(negedge clk);
        end
        @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R11 ready low after last byte", in_ready, 0);
    endtask

    task automatic packet(int len, int seed, int gap);
        bit filled, missed;
        int r0 = n_rint, i0 = n_intr, q0 = n_irq, m0 = n_miss;
        int st_addr = BASE + mptr * 8 + 2;
        predict(len, seed, filled, missed);
        if (filled) st_addr = q_a[q_a.size() - 1];
        send(len, seed, gap);
        repeat (8) @(negedge clk);
        chk(q_a.size() == 0, "R6 all writes done", q_a.size(), 0);
        chk(n_rint - r0 == int'(filled), "R8 rint count", n_rint - r0, int'(filled));
        chk(n_intr - i0 == int'(filled), "R8 intr count", n_intr - i0, int'(filled));
        chk(n_irq - q0 == int'(filled && inea_i), "R8 irq gating", n_irq - q0,
            int'(filled && inea_i));
        chk(n_miss - m0 == int'(missed), "R10 miss count", n_miss - m0, int'(missed));
        if (filled)
            chk(rd(st_addr) == 8'h03, "R6 status returned", rd(st_addr), 3);
    endtask

    initial begin
        for (int i = 0; i < N; i++) set_desc(i, 'h3A0000 + i * 'h400, 8'h80);
        repeat (3) @(negedge clk);
        chk(!in_ready && !mem_req && !rint && !intr && !irq && !miss, "R1 reset outputs",
            int'({in_ready, mem_req, rint, miss}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!in_ready && !mem_req, "R1 idle after reset", int'({in_ready, mem_req}), 0);

        packet(5, 'h11, 0);                 // R1: lands in entry 0, R2/R5
        inea_i = 1'b0;
        packet(1, 'h40, 2);                 // R8: no irq with inea low
        inea_i = 1'b1;
        set_desc(2, 'h3A0800, 8'h81);       // R3: not exactly owned
        packet(3, 'h25, 1);                 // goes to entry 3, pointer wraps (R7)
        set_desc(0, 'h3A0000, 8'h03);
        set_desc(1, 'h3A0400, 8'h00);
        set_desc(3, 'h3A0C00, 8'h80);       // R4: entry before pointer is owned
        packet(4, 'h77, 0);                 // expect miss (R10)
        set_desc(0, 'h3A0000, 8'h80);
        stop_i = 1'b1;
        packet(6, 'h05, 0);                 // R9: ignored
        stop_i = 1'b0;
        packet(2, 'h63, 0);                 // pointer unchanged: entry 0
        set_desc(1, 'h3A0400, 8'h80);
        packet(300, 'h9C, 0);               // R6: length 0x0130

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule